// File: doc/BRIEF.md
# Five-Moduli Residue-to-Binary Converter

This block turns a number held as five residues back into its ordinary binary value. The moduli are 2^n-1, 2^n, 2^n+1, 2^(n+1)-1 and 2^(n-1)-1, where n is an even parameter. Any two of these moduli are coprime. Together they cover every integer from 0 up to their product M, minus one. A residue tuple arrives with a valid strobe. The binary value appears a fixed number of cycles later with its own strobe.

The reconstruction runs in two phases. In the front phase, the channels 2^n-1, 2^n+1, 2^(n+1)-1 and 2^n are merged into one value modulo their combined product. In the back phase, a two-moduli mixed-radix step folds in the 2^(n-1)-1 channel.

Every step is built from the same few parts:
- end-around-carry adders,
- constant rotations for the modular inverses,
- shift-and-add constant scaling.

The datapath has no multiplier and no table. A register follows each step, so the block takes a new tuple on every clock. M exceeds 2^(5n-1), so the result port is 5n bits wide.

Top module: `rns5_to_bin`

## Requirements
- R1: For every X with 0 <= X < M, presenting the residues of X (res_lo = X mod 2^n-1, res_pw = X mod 2^n, res_hi = X mod 2^n+1, res_wide = X mod 2^(n+1)-1, res_nar = X mod 2^(n-1)-1) produces out_bin = X.
- R2: The latency is fixed at 4 clocks. A tuple sampled with in_vld high at a rising edge shows up with out_vld high after the 4th rising edge from there.
- R3: A tuple is accepted on every cycle in which in_vld is high, including back-to-back cycles. Results leave in arrival order, one per accepted tuple, and none appears for a cycle with in_vld low.
- R4: While rst is high at a rising edge, all valid stages clear. out_vld is low during reset and stays low afterwards until a tuple accepted after reset has had time to emerge.
- R5: The low n bits of out_bin always equal the 2^n-channel residue of the same tuple.
- R6: In the three channels whose modulus has the form 2^k-1 (res_lo, res_wide, res_nar), the all-ones input pattern is taken as residue zero. It gives the same result as the zero pattern.
- R7: out_bin is always less than M whenever out_vld is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the valid stages |
| in_vld | input | 1 | The residue tuple on the inputs is valid this cycle |
| res_lo | input | N | Residue modulo 2^N-1 |
| res_pw | input | N | Residue modulo 2^N |
| res_hi | input | N+1 | Residue modulo 2^N+1 (0 to 2^N) |
| res_wide | input | N+1 | Residue modulo 2^(N+1)-1 |
| res_nar | input | N-1 | Residue modulo 2^(N-1)-1 |
| out_vld | output | 1 | out_bin holds a converted result |
| out_bin | output | 5N | Reconstructed binary value, below M |

## Verification
Acceptance of a fresh tuple and delivery of an older result happen in the same cycle whenever tuples arrive back to back. The bench provokes this with a long sweep of values spaced across the whole range, broken by occasional single idle cycles. A scoreboard judges each result against its own expected value and against the cycle its tuple entered plus four.

A mid-stream reset also collides with tuples still in flight. The bench judges that case by watching that no result from before the reset ever emerges.

// File: rtl/rns5_pkg.sv
package rns5_pkg;

   typedef logic [127:0] wide_t;

   // 2^k - 1 as a wide constant
   function automatic wide_t pow2m1(input int k);
      return (wide_t'(1) << k) - wide_t'(1);
   endfunction

   // v mod m, bit-serial Horner evaluation (elaboration only)
   function automatic longint wide_mod(input wide_t v, input longint m);
      longint r;
      r = 0;
      for (int i = 127; i >= 0; i--) begin
         r = (r * 2 + longint'(v[i])) % m;
      end
      return r;
   endfunction

   // multiplicative inverse of a modulo m by the extended Euclid recurrence
   function automatic longint modinv(input longint a, input longint m);
      longint t, nt, r, nr, q, tmp;
      t  = 0;
      nt = 1;
      r  = m;
      nr = a % m;
      while (nr != 0) begin
         q   = r / nr;
         tmp = t - q * nt;
         t   = nt;
         nt  = tmp;
         tmp = r - q * nr;
         r   = nr;
         nr  = tmp;
      end
      if (t < 0) t = t + m;
      return t;
   endfunction

endpackage

// File: rtl/rns_delay.sv
module rns_delay #(
   parameter int W   = 1,
   parameter int D   = 1,
   parameter bit CLR = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stg [D];

   initial begin
      assert (D >= 1) else $error("rns_delay: depth must be at least one");
   end

   generate
      for (genvar g = 0; g < D; g++) begin : g_stg
         if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (CLR && rst) stg[0] <= '0;
               else            stg[0] <= d_i;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (CLR && rst) stg[g] <= '0;
               else            stg[g] <= stg[g-1];
            end
         end
      end
   endgenerate

   assign q_o = stg[D-1];

endmodule

// File: rtl/rns_mersenne_step.sv
// One mixed-radix step against a modulus of the form 2^K-1:
//   y = x + MOLD * (((r - x) * MOLD^-1) mod (2^K-1)), registered.
module rns_mersenne_step #(
   parameter int             XW   = 5,
   parameter int             K    = 4,
   parameter int             OW   = 8,
   parameter rns5_pkg::wide_t MOLD = 128'd17
) (
   input  logic          clk,
   input  logic [XW-1:0] x_i,
   input  logic [K-1:0]  r_i,
   output logic [OW-1:0] y_o
);
   import rns5_pkg::*;

   localparam longint MODV = (longint'(1) << K) - 1;
   localparam longint INV  = modinv(wide_mod(MOLD, MODV), MODV);
   localparam int     NC   = (XW + K - 1) / K;
   localparam int     PW   = NC * K;

   initial begin
      assert (K >= 2 && K <= 30) else $error("rns_mersenne_step: K out of range");
      assert (OW <= 120)         else $error("rns_mersenne_step: OW too wide");
      assert (INV != 0)          else $error("rns_mersenne_step: MOLD not invertible");
   end

   // end-around-carry addition modulo 2^K-1 (all-ones is a second zero)
   function automatic logic [K-1:0] eac(input logic [K-1:0] a, input logic [K-1:0] b);
      logic [K:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[K-1:0] + {{(K-1){1'b0}}, s[K]};
   endfunction

   logic [K-1:0]  x_fold;
   logic [K-1:0]  diff;
   logic [K-1:0]  tdig;
   logic [OW-1:0] y_nxt;

   // fold x into K-bit slices, summed with end-around carry
   always_comb begin
      logic [PW-1:0] xp;
      logic [K-1:0]  acc;
      xp  = PW'(x_i);
      acc = '0;
      for (int c = 0; c < NC; c++) begin
         acc = eac(acc, xp[c*K +: K]);
      end
      x_fold = acc;
   end

   // r - x modulo 2^K-1: add the ones complement
   assign diff = eac(r_i, ~x_fold);

   // constant inverse as a sum of rotations, then normalise all-ones to zero
   always_comb begin
      logic [2*K-1:0] dd;
      logic [K-1:0]   acc;
      dd  = {diff, diff};
      acc = '0;
      for (int i = 0; i < K; i++) begin
         if (INV[i]) acc = eac(acc, dd[(2*K-1-i) -: K]);
      end
      tdig = (acc == {K{1'b1}}) ? '0 : acc;
   end

   // scale the digit by MOLD with shifted adds and add to x
   always_comb begin
      logic [OW-1:0] prod;
      prod = '0;
      for (int i = 0; i < OW; i++) begin
         if (MOLD[i]) prod = prod + (OW'(tdig) << i);
      end
      y_nxt = OW'(x_i) + prod;
   end

   always_ff @(posedge clk) begin
      y_o <= y_nxt;
   end

endmodule

// File: rtl/rns_pow2_step.sv
// Mixed-radix step against the modulus 2^K:
//   y = x + MOLD * (((r - x) * MOLD^-1) mod 2^K), registered.
module rns_pow2_step #(
   parameter int             XW   = 8,
   parameter int             K    = 4,
   parameter int             OW   = 12,
   parameter rns5_pkg::wide_t MOLD = 128'd255
) (
   input  logic          clk,
   input  logic [XW-1:0] x_i,
   input  logic [K-1:0]  r_i,
   output logic [OW-1:0] y_o
);
   import rns5_pkg::*;

   localparam longint MODV = longint'(1) << K;
   localparam longint INV  = modinv(wide_mod(MOLD, MODV), MODV);

   initial begin
      assert (XW >= K)                  else $error("rns_pow2_step: x narrower than K");
      assert (K >= 2 && K <= 30)        else $error("rns_pow2_step: K out of range");
      assert (OW <= 120)                else $error("rns_pow2_step: OW too wide");
      assert (wide_mod(MOLD, 2) == 1)   else $error("rns_pow2_step: MOLD must be odd");
   end

   logic [K-1:0]  diff;
   logic [K-1:0]  tdig;
   logic [OW-1:0] y_nxt;

   assign diff = r_i - x_i[K-1:0];

   // inverse modulo 2^K as truncated shifted adds
   always_comb begin
      logic [K-1:0] acc;
      acc = '0;
      for (int i = 0; i < K; i++) begin
         if (INV[i]) acc = acc + (diff << i);
      end
      tdig = acc;
   end

   always_comb begin
      logic [OW-1:0] prod;
      prod = '0;
      for (int i = 0; i < OW; i++) begin
         if (MOLD[i]) prod = prod + (OW'(tdig) << i);
      end
      y_nxt = OW'(x_i) + prod;
   end

   always_ff @(posedge clk) begin
      y_o <= y_nxt;
   end

endmodule

// File: rtl/rns5_to_bin.sv
module rns5_to_bin #(
   parameter int N = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_vld,
   input  logic [N-1:0]   res_lo,
   input  logic [N-1:0]   res_pw,
   input  logic [N:0]     res_hi,
   input  logic [N:0]     res_wide,
   input  logic [N-2:0]   res_nar,
   output logic           out_vld,
   output logic [5*N-1:0] out_bin
);
   import rns5_pkg::*;

   localparam int LAT = 4;
   localparam int W_Y = 2 * N;
   localparam int W_Z = 3 * N + 1;
   localparam int W_Q = 4 * N + 1;
   localparam int W_O = 5 * N;

   // running moduli products after each step
   localparam wide_t M_A = pow2m1(N) + wide_t'(2);
   localparam wide_t M_B = pow2m1(2 * N);
   localparam wide_t M_C = M_B * pow2m1(N + 1);
   localparam wide_t M_D = M_C << N;

   initial begin
      assert (N % 2 == 0)       else $error("rns5_to_bin: N must be even");
      assert (N >= 4 && N <= 24) else $error("rns5_to_bin: N must lie in 4..24");
   end

   logic [W_Y-1:0] y_q;
   logic [W_Z-1:0] z_q;
   logic [W_Q-1:0] q_q;
   logic [N:0]     wide_d;
   logic [N-1:0]   pw_d;
   logic [N-2:0]   nar_d;

   // front phase, step a: pair 2^N+1 with 2^N-1 -> value mod 2^2N-1
   rns_mersenne_step #(.XW(N + 1), .K(N), .OW(W_Y), .MOLD(M_A)) u_pair (
      .clk (clk), .x_i (res_hi), .r_i (res_lo), .y_o (y_q));

   rns_delay #(.W(N + 1), .D(1), .CLR(1'b0)) u_dly_wide (
      .clk (clk), .rst (rst), .d_i (res_wide), .q_o (wide_d));

   // front phase, step b: fold in 2^(N+1)-1
   rns_mersenne_step #(.XW(W_Y), .K(N + 1), .OW(W_Z), .MOLD(M_B)) u_wide (
      .clk (clk), .x_i (y_q), .r_i (wide_d), .y_o (z_q));

   rns_delay #(.W(N), .D(2), .CLR(1'b0)) u_dly_pw (
      .clk (clk), .rst (rst), .d_i (res_pw), .q_o (pw_d));

   // front phase, step c: fold in 2^N, giving the four-moduli value
   rns_pow2_step #(.XW(W_Z), .K(N), .OW(W_Q), .MOLD(M_C)) u_pw (
      .clk (clk), .x_i (z_q), .r_i (pw_d), .y_o (q_q));

   rns_delay #(.W(N - 1), .D(3), .CLR(1'b0)) u_dly_nar (
      .clk (clk), .rst (rst), .d_i (res_nar), .q_o (nar_d));

   // back phase: two-moduli mixed-radix merge with 2^(N-1)-1
   rns_mersenne_step #(.XW(W_Q), .K(N - 1), .OW(W_O), .MOLD(M_D)) u_nar (
      .clk (clk), .x_i (q_q), .r_i (nar_d), .y_o (out_bin));

   rns_delay #(.W(1), .D(LAT), .CLR(1'b1)) u_dly_vld (
      .clk (clk), .rst (rst), .d_i (in_vld), .q_o (out_vld));

endmodule

// File: rtl/rns5_to_bin_chk.sv
module rns5_to_bin_chk #(
   parameter int N = 4
) (
   input logic           clk,
   input logic           rst,
   input logic           in_vld,
   input logic [N-1:0]   res_pw,
   input logic           out_vld,
   input logic [5*N-1:0] out_bin
);
   import rns5_pkg::*;

   localparam wide_t M_ALL = ((pow2m1(2 * N) * pow2m1(N + 1)) << N) * pow2m1(N - 1);

   logic [2:0] warm;

   always_ff @(posedge clk) begin
      if (rst)             warm <= '0;
      else if (warm != 3'd4) warm <= warm + 3'd1;
   end

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (rst)
      (warm == 3'd4) |-> (out_vld == $past(in_vld, 4)));

   // R5
   low_digit_chk: assert property (@(posedge clk) disable iff (rst)
      (out_vld && warm == 3'd4) |-> (out_bin[N-1:0] == $past(res_pw, 4)));

   // R7
   in_range_chk: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (wide_t'(out_bin) < M_ALL));

   // R4
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_vld);

endmodule

bind rns5_to_bin rns5_to_bin_chk #(.N(N)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .in_vld  (in_vld),
   .res_pw  (res_pw),
   .out_vld (out_vld),
   .out_bin (out_bin)
);

// File: tb/rns5_to_bin_tb_top.sv
`timescale 1ns/1ps
module rns5_to_bin_tb_top;

   localparam int     N    = 4;
   localparam longint MLO  = (longint'(1) << N) - 1;
   localparam longint MPW  = longint'(1) << N;
   localparam longint MHI  = (longint'(1) << N) + 1;
   localparam longint MWD  = (longint'(1) << (N + 1)) - 1;
   localparam longint MNR  = (longint'(1) << (N - 1)) - 1;
   localparam longint MTOT = MLO * MPW * MHI * MWD * MNR;

   typedef struct {
      longint x;
      longint stamp;
      bit     ones;
   } exp_t;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           in_vld = 1'b0;
   logic [N-1:0]   res_lo = '0;
   logic [N-1:0]   res_pw = '0;
   logic [N:0]     res_hi = '0;
   logic [N:0]     res_wide = '0;
   logic [N-2:0]   res_nar = '0;
   logic           out_vld;
   logic [5*N-1:0] out_bin;

   longint cyc = 0;
   int     n_chk = 0;
   int     n_bad = 0;
   bit     done = 1'b0;
   exp_t   sbq[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rns5_to_bin #(.N(N)) dut_i (
      .clk (clk), .rst (rst), .in_vld (in_vld),
      .res_lo (res_lo), .res_pw (res_pw), .res_hi (res_hi),
      .res_wide (res_wide), .res_nar (res_nar),
      .out_vld (out_vld), .out_bin (out_bin));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: residues of x, all-ones stands in for zero when ones is set (R6)
   task automatic send(input longint x, input bit ones);
      longint a, d, e;
      bit     used;
      a = x % MLO;
      d = x % MWD;
      e = x % MNR;
      used = 1'b0;
      if (ones && a == 0) begin a = MLO; used = 1'b1; end
      if (ones && d == 0) begin d = MWD; used = 1'b1; end
      if (ones && e == 0) begin e = MNR; used = 1'b1; end
      @(negedge clk);
      in_vld   = 1'b1;
      res_lo   = N'(a);
      res_pw   = N'(x % MPW);
      res_hi   = (N + 1)'(x % MHI);
      res_wide = (N + 1)'(d);
      res_nar  = (N - 1)'(e);
      sbq.push_back('{x, cyc + 4, used});
   endtask

   task automatic idle(input int k);
      repeat (k) begin
         @(negedge clk);
         in_vld = 1'b0;
      end
   endtask

   // monitor: compare each result against the scoreboard head
   always @(negedge clk) begin
      exp_t e;
      if (!rst && out_vld) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R3 result with no accepted tuple", longint'(out_bin), -1);
         end else begin
            e = sbq.pop_front();
            chk(longint'(out_bin) == e.x, e.ones ? "R6 all-ones residue value" : "R1 value",
                longint'(out_bin), e.x);
            chk(cyc == e.stamp, "R2 latency", cyc, e.stamp);
            chk(longint'(out_bin[N-1:0]) == e.x % MPW, "R5 low digit",
                longint'(out_bin[N-1:0]), e.x % MPW);
            chk(longint'(out_bin) < MTOT, "R7 below range", longint'(out_bin), MTOT - 1);
         end
      end
   end

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   always @(posedge clk) begin
      if (!done && cyc > 120000) begin
         done = 1'b1;
         chk(1'b0, "watchdog expired", cyc, 120000);
         summary();
         $finish;
      end
   end

   initial begin
      // R4: in_vld high during reset must not leak through
      in_vld = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk(out_vld == 1'b0, "R4 out_vld during reset", longint'(out_vld), 0);
      end
      @(negedge clk);
      rst = 1'b0;
      in_vld = 1'b0;
      repeat (6) begin
         @(negedge clk);
         chk(out_vld == 1'b0, "R4 out_vld after reset", longint'(out_vld), 0);
      end

      // corners, each with and without all-ones zero codes (R1, R6)
      for (int p = 0; p < 2; p++) begin
         send(0, p[0]);
         send(1, p[0]);
         send(MLO, p[0]);
         send(MPW, p[0]);
         send(MWD * MNR, p[0]);
         send(MLO * MWD * MNR, p[0]);
         send(MTOT / 2, p[0]);
         send(MTOT - 2, p[0]);
         send(MTOT - 1, p[0]);
      end
      idle(6);

      // R1/R3: spaced sweep over the whole range, back to back with sparse gaps
      for (longint x = 0; x < MTOT; x += 29) begin
         send(x, ((x / 29) % 2) == 1);
         if ((x / 29) % 13 == 12) idle(1);
      end
      idle(8);

      // R4: reset with tuples in flight
      send(12345, 1'b0);
      send(23456, 1'b0);
      send(34567, 1'b0);
      @(negedge clk);
      rst = 1'b1;
      in_vld = 1'b0;
      sbq.delete();
      repeat (2) @(negedge clk);
      rst = 1'b0;
      repeat (6) begin
         @(negedge clk);
         chk(out_vld == 1'b0, "R4 no result after mid-stream reset", longint'(out_vld), 0);
      end

      // R3: burst after reset, every tuple delivered
      for (int k = 0; k < 20; k++) send(MTOT - 1 - longint'(k) * 7, k[0]);
      idle(8);
      chk(sbq.size() == 0, "R3 all accepted tuples delivered", longint'(sbq.size()), 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule